// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block drives one pulse-width-modulated output from an 8-bit up-counting timer. The timer advances once every 4 × N clock cycles, where N is a prescale ratio of 1, 4 or 16. Within each timer step a 2-bit fine phase subdivides the step, so the pulse edge can be placed to within N clocks. The pulse width is a 10-bit value made of an 8-bit coarse part and a 2-bit fine part. The waveform repeats each time the timer reaches an 8-bit period limit.

Software writes the period, the duty and a control byte through a simple write port. Duty writes go to holding registers. The comparator only ever sees a shadow copy, which is refreshed at the instant the timer wraps. A duty change made in the middle of a cycle therefore never shortens or stretches the pulse already in progress. A one-cycle flag marks every wrap of the timer.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After reset the output and the flag are low, the duty is 0, the timer is stopped, and the period limit is 0xFF. With the default limit, prescale 1 and the timer enabled, wraps occur every 1024 clocks.
- R2: Writes occur on a rising edge with `wr_en` high. Address 0 sets the period limit P. Address 2 is the control byte: bits [1:0] select the prescale (00 → N=1, 01 → N=4, 10 or 11 → N=16), bit 2 enables the timer, bit 3 enables PWM output, and bits [5:4] are the fine duty bits. With the timer enabled, successive wraps are (P+1)·4·N clocks apart.
- R3: Address 1 holds the coarse duty bits. The duty D is {coarse, fine}. For 0 < D < (P+1)·4, the output is high for exactly D·N clocks, starting in the cycle the flag is raised.
- R4: A duty written during a cycle does not change that cycle. It takes effect from the next wrap.
- R5: With D = 0 the output stays low for the whole cycle.
- R6: With D ≥ (P+1)·4 the output is never cleared, so it stays high for the whole cycle.
- R7: The flag is high for one clock at each wrap, and the output rises only in a flag cycle.
- R8: With the PWM enable bit clear, the output is low from the next clock onward. Wraps and flags continue.
- R9: With the timer enable bit clear, the timer and fine phase freeze, no flag is raised, and the output holds its level.
- R10: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM waveform |
| match_flag | output | 1 | One-cycle pulse at each timer wrap |

## Verification
A write lands on the rising edge that samples it. The flag and the rising output edge appear one edge after the timer sits at its limit on the last prescaled clock. The falling edge appears in the first cycle whose count equals the duty, because the comparator looks at the next count value. The bench samples on falling edges and measures every result as an interval that opens on one flag cycle and closes on the next. That interval covers both the high-time count and the period count, so the fixed pipeline offset cancels out. Mid-cycle writes are timed by cycle number inside that interval, so they fall inside the cycle being measured.

// File: rtl/pwm_pkg.sv
// Shared types and helpers for the double-buffered PWM generator.
// Assumes the prescale select is two bits wide.
package pwm_pkg;

    localparam logic [1:0] ADDR_PERIOD  = 2'd0;
    localparam logic [1:0] ADDR_DUTY_HI = 2'd1;
    localparam logic [1:0] ADDR_CTRL    = 2'd2;

    // Control byte layout, bits [5:0]
    typedef struct packed {
        logic [1:0] duty_lo;
        logic       mode_en;
        logic       tmr_en;
        logic [1:0] ps_sel;
    } ctrl_t;

    // log2 of the prescale ratio: 00 -> 0, 01 -> PS_W/2, 1x -> PS_W
    function automatic int ps_shift(input logic [1:0] sel, input int ps_w);
        if (sel[1])      return ps_w;
        else if (sel[0]) return ps_w / 2;
        else             return 0;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
// Prescaler plus fine phase. One counter spans 4*N clocks per timer step;
// its top FINE_W bits at the current prescale form the fine phase.
// Assumes a prescale change mid-step is tolerated (>= compare wraps it).
module pwm_timebase #(
    parameter int FINE_W = 2,
    parameter int PS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        ps_sel,
    output logic              tick,
    output logic [FINE_W-1:0] fine_nxt
);
    localparam int CNT_W = FINE_W + PS_W;

    logic [CNT_W-1:0] cnt_q, cnt_nxt, lim;
    int               sh;

    // Step limit and timer-advance strobe for the selected ratio
    always_comb begin
        sh   = pwm_pkg::ps_shift(ps_sel, PS_W);
        lim  = CNT_W'((64'd1 << (FINE_W + sh)) - 64'd1);
        tick = run && (cnt_q >= lim);
    end

    // Next count and the fine phase it implies
    always_comb begin
        if (!run)      cnt_nxt = cnt_q;
        else if (tick) cnt_nxt = '0;
        else           cnt_nxt = cnt_q + 1'b1;
        fine_nxt = FINE_W'(cnt_nxt >> sh);
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/pwm_period_timer.sv
// Coarse timer. Advances on each tick and returns to zero on the tick
// taken while it equals the period limit.
// Assumes a limit below the current count lets the timer wrap naturally.
module pwm_period_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] tmr_nxt,
    output logic             rollover
);
    logic [TMR_W-1:0] tmr_q;

    // Wrap detection and next timer value
    always_comb begin
        rollover = tick && (tmr_q == period);
        if (rollover)  tmr_nxt = '0;
        else if (tick) tmr_nxt = tmr_q + 1'b1;
        else           tmr_nxt = tmr_q;
    end

    // Timer register
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_nxt;
    end
endmodule

// File: rtl/pwm_duty_buffer.sv
// Shadow duty register. It copies the software duty only on a wrap, so
// the comparator never sees a half-written or mid-cycle value.
module pwm_duty_buffer #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_wr,
    output logic [DUTY_W-1:0] shadow_q
);
    // Load the shadow at the period boundary only
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (load) shadow_q <= duty_wr;
    end
endmodule

// File: rtl/pwm_out_stage.sv
// Registered output and wrap flag. Set on a wrap with a nonzero new duty.
// Cleared when the next count equals the shadow duty, so the low level
// lands in the matching cycle. Forced low when PWM mode is off.
module pwm_out_stage #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              rollover,
    input  logic [DUTY_W-1:0] duty_new,
    input  logic [DUTY_W-1:0] shadow,
    input  logic [DUTY_W-1:0] cnt_nxt,
    output logic              pwm_q,
    output logic              flag_q
);
    logic pwm_nxt;

    // Output next-state: mode gate, then wrap, then match
    always_comb begin
        if (!mode_en)                pwm_nxt = 1'b0;
        else if (rollover)           pwm_nxt = (duty_new != '0);
        else if (cnt_nxt == shadow)  pwm_nxt = 1'b0;
        else                         pwm_nxt = pwm_q;
    end

    // Output and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pwm_q  <= pwm_nxt;
            flag_q <= rollover;
        end
    end
endmodule

// File: rtl/pwm_dbuf_gen.sv
// Top level: holds the write-port registers and ties together the
// timebase, coarse timer, shadow duty and output stage.
// Assumes wr_data is wide enough for the 6-bit control byte.
module pwm_dbuf_gen #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int PS_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             match_flag
);
    import pwm_pkg::*;

    localparam int DUTY_W = TMR_W + FINE_W;
    localparam int CTRL_W = $bits(ctrl_t);

    logic [TMR_W-1:0]  period_q, duty_hi_q, tmr_nxt;
    ctrl_t             ctrl_q;
    logic              tick, rollover, mode_en, tmr_en;
    logic [FINE_W-1:0] fine_nxt;
    logic [DUTY_W-1:0] duty_wr, shadow_duty, cnt_nxt;

    // Software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q  <= '1;
            duty_hi_q <= '0;
            ctrl_q    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD:  period_q  <= wr_data;
                ADDR_DUTY_HI: duty_hi_q <= wr_data;
                ADDR_CTRL:    ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:      ;
            endcase
        end
    end

    // Field extraction and count/duty assembly
    always_comb begin
        mode_en = ctrl_q.mode_en;
        tmr_en  = ctrl_q.tmr_en;
        duty_wr = {duty_hi_q, ctrl_q.duty_lo};
        cnt_nxt = {tmr_nxt, fine_nxt};
    end

    pwm_timebase #(.FINE_W(FINE_W), .PS_W(PS_W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_en),
        .ps_sel   (ctrl_q.ps_sel),
        .tick     (tick),
        .fine_nxt (fine_nxt)
    );

    pwm_period_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .period   (period_q),
        .tmr_nxt  (tmr_nxt),
        .rollover (rollover)
    );

    pwm_duty_buffer #(.DUTY_W(DUTY_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rollover),
        .duty_wr  (duty_wr),
        .shadow_q (shadow_duty)
    );

    pwm_out_stage #(.DUTY_W(DUTY_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_en  (mode_en),
        .rollover (rollover),
        .duty_new (duty_wr),
        .shadow   (shadow_duty),
        .cnt_nxt  (cnt_nxt),
        .pwm_q    (pwm_out),
        .flag_q   (match_flag)
    );
endmodule

// File: rtl/pwm_dbuf_gen_chk.sv
// Temporal checks for pwm_dbuf_gen, attached by bind below.
module pwm_dbuf_gen_chk #(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic              match_flag,
    input logic              mode_en,
    input logic              tmr_en,
    input logic [DUTY_W-1:0] shadow_duty
);
    // R7: flag lasts a single clock
    p_flag_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag |=> !match_flag);

    // R7: output rises only together with the wrap flag
    p_rise_on_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> match_flag);

    // R8: PWM mode off forces the output low on the next clock
    p_mode_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !pwm_out);

    // R9: a stopped timer raises no flag
    p_frozen_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> !match_flag);

    // R5: a zero active duty never drives the output high
    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_duty == '0) |-> !pwm_out);

    // R4: the active duty changes only in a wrap cycle
    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !match_flag |-> $stable(shadow_duty));
endmodule

bind pwm_dbuf_gen pwm_dbuf_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_out     (pwm_out),
    .match_flag  (match_flag),
    .mode_en     (mode_en),
    .tmr_en      (tmr_en),
    .shadow_duty (shadow_duty)
);

// File: tb/pwm_dbuf_gen_tb.sv
module pwm_dbuf_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, match_flag;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    pwm_dbuf_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .match_flag(match_flag)
    );

    typedef struct packed {
        logic [1:0]  ps;
        logic [7:0]  pr;
        logic [9:0]  duty;
        logic [15:0] exp_hi;
        logic [15:0] exp_per;
    } vec_t;

    // high = D*N, period = (P+1)*4*N
    localparam vec_t VEC [8] = '{
        '{2'd0, 8'd9,   10'd17,   16'd17,   16'd40},
        '{2'd1, 8'd4,   10'd7,    16'd28,   16'd80},
        '{2'd2, 8'd3,   10'd10,   16'd160,  16'd256},
        '{2'd3, 8'd2,   10'd1,    16'd16,   16'd192},
        '{2'd0, 8'd0,   10'd3,    16'd3,    16'd4},
        '{2'd1, 8'd7,   10'd32,   16'd128,  16'd128},
        '{2'd0, 8'd5,   10'd0,    16'd0,    16'd24},
        '{2'd0, 8'd255, 10'd1023, 16'd1023, 16'd1024}
    };

    function automatic logic [7:0] ctl(input logic [1:0] ps, input logic ten,
                                       input logic mode, input logic [1:0] lo);
        return {2'b00, lo, mode, ten, ps};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_flag(output bit ok);
        int n = 0;
        while (!match_flag && n < 20000) begin
            @(negedge clk);
            n++;
        end
        ok = match_flag;
    endtask

    // Called on a flag cycle; returns at the next flag cycle
    task automatic measure(output int hi, output int per, input bit dw,
                           input int at, input logic [1:0] a, input logic [7:0] d);
        hi = 0; per = 0;
        do begin
            if (pwm_out) hi++;
            if (dw && per == at) begin
                wr_en = 1'b1; wr_addr = a; wr_data = d;
            end
            if (dw && per == at + 1) wr_en = 1'b0;
            @(negedge clk);
            per++;
        end while (!match_flag && per < 20000);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok;
        int hi, per, fl, hc;
        @(negedge clk);

        // R1: reset state and default period limit
        do_reset();
        chk("R1 out after reset", int'(pwm_out), 0);
        chk("R1 flag after reset", int'(match_flag), 0);
        repeat (20) @(negedge clk);
        chk("R1 no flag while timer stopped", int'(match_flag), 0);
        wr(2'd2, ctl(2'd0, 1'b1, 1'b1, 2'd0));
        wait_flag(ok);
        chk("R1 first wrap", int'(ok), 1);
        measure(hi, per, 1'b0, 0, 2'd0, 8'd0);
        chk("R1 default period", per, 1024);
        chk("R5 reset duty zero high", hi, 0);

        // Vector table: R2 period, R3/R5/R6 high time
        for (int i = 0; i < 8; i++) begin
            string rq;
            do_reset();
            wr(2'd0, VEC[i].pr);
            wr(2'd1, VEC[i].duty[9:2]);
            wr(2'd2, ctl(VEC[i].ps, 1'b1, 1'b1, VEC[i].duty[1:0]));
            wait_flag(ok);
            chk("R2 wrap reached", int'(ok), 1);
            measure(hi, per, 1'b0, 0, 2'd0, 8'd0);
            chk("R2 period", per, int'(VEC[i].exp_per));
            rq = (VEC[i].exp_hi == 0) ? "R5 high time" :
                 (VEC[i].exp_hi == VEC[i].exp_per) ? "R6 high time" : "R3 high time";
            chk(rq, hi, int'(VEC[i].exp_hi));
        end

        // R7: flag width and rising edge alignment
        do_reset();
        wr(2'd0, 8'd9);
        wr(2'd1, 8'd5);
        wr(2'd2, ctl(2'd0, 1'b1, 1'b1, 2'd0));
        wait_flag(ok);
        chk("R7 output high in flag cycle", int'(pwm_out), 1);
        @(negedge clk);
        chk("R7 flag one cycle", int'(match_flag), 0);
        wait_flag(ok);

        // R4: mid-cycle duty write applies next cycle (20 -> 4)
        measure(hi, per, 1'b1, 5, 2'd1, 8'd1);
        chk("R4 current cycle unchanged", hi, 20);
        measure(hi, per, 1'b0, 0, 2'd0, 8'd0);
        chk("R4 next cycle new duty", hi, 4);

        // R10: write to address 3 ignored
        measure(hi, per, 1'b1, 3, 2'd3, 8'hFF);
        measure(hi, per, 1'b0, 0, 2'd0, 8'd0);
        chk("R10 period unchanged", per, 40);
        chk("R10 duty unchanged", hi, 4);

        // R8: PWM mode off, flags continue
        wr(2'd2, ctl(2'd0, 1'b1, 1'b0, 2'd0));
        wait_flag(ok);
        measure(hi, per, 1'b0, 0, 2'd0, 8'd0);
        chk("R8 output low with mode off", hi, 0);
        chk("R8 wraps continue", per, 40);

        // R9: timer stop freezes everything
        wr(2'd1, 8'd5);
        wr(2'd2, ctl(2'd0, 1'b1, 1'b1, 2'd0));
        wait_flag(ok);
        @(negedge clk);
        wait_flag(ok);
        repeat (3) @(negedge clk);
        wr(2'd2, ctl(2'd0, 1'b0, 1'b1, 2'd0));
        fl = 0; hc = 0;
        for (int k = 0; k < 100; k++) begin
            if (match_flag) fl++;
            if (pwm_out) hc++;
            @(negedge clk);
        end
        chk("R9 no flag while stopped", fl, 0);
        chk("R9 output held high", hc, 100);
        wr(2'd2, ctl(2'd0, 1'b1, 1'b1, 2'd0));
        wait_flag(ok);
        chk("R9 resumes after enable", int'(ok), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule